// File: doc/BRIEF.md
# Host-to-Core Mailbox with Status Flags

This block carries single words in both directions between an external host port and an embedded processor core. Each direction has a one-word staging buffer on the sending side and a holding register on the receiving side. A small state machine per direction decides when a staged word may move across. A word moves only when the receiving register is free, so no word is overwritten before it has been consumed.

The core sees a 16-bit read-only status word. It holds the receive-full and transmit-empty flags, a pending host command bit, two general flags written by the host, and a DMA-enabled indication derived from two host mode bits. The flags also drive the receive and transmit DMA requests and a maskable command interrupt. The host can reset both data paths at once with a single-cycle initialize strobe.

The design has four state machines:
- Host-to-core path `mbox_h2c`, with states `H2C_IDLE` and `H2C_HELD`. IDLE goes to HELD on a host write. HELD goes back to IDLE when the word moves to the core.
- Core-to-host path `mbox_c2h`, with states `C2H_EMPTY` and `C2H_LOADED`. EMPTY goes to LOADED on a core write. LOADED goes back to EMPTY when the word moves to the host.
- Command tracker `mbox_cmd`, with states `CMD_IDLE` and `CMD_PEND`. A host write of 1 moves it to PEND. A host write of 0 or a core acknowledge moves it to IDLE.
- DMA tracker `mbox_dma`, with states `DMA_IDLE` and `DMA_ARMED`. It goes to ARMED when a mode bit is set. It goes back to IDLE once both mode bits are clear and both paths are empty.

In every machine, the initialize strobe forces the data paths to IDLE and EMPTY.

Top module: `mbox_top`

## Requirements
- R1: The status word `c_status` has this layout: bit 0 is receive-full, bit 1 is transmit-empty, bit 2 is command-pending, bit 3 is host flag 0, bit 4 is host flag 1, and bit 5 is DMA-enabled. Bits 15 to 6 read 0.
- R2: After reset, `c_status` reads 0x0002, `h_txe` is 1, `h_rxf` is 0, `c_irq` is 0, `dma_rx_req` is 0 and `dma_tx_req` is 1.
- R3: After a host write to an idle path with receive-full at 0, `h_txe` drops after that edge. The word appears on `c_rx_data` with receive-full set after the next edge. A core read clears receive-full at the following edge.
- R4: A core write clears transmit-empty at that edge. If `h_rxf` is 0, the next edge moves the word to `h_rx_data`, sets `h_rxf` and sets transmit-empty again. A host read clears `h_rxf`.
- R5: An initialize strobe sets transmit-empty, clears receive-full, discards staged words in both directions and sets `h_txe`. It takes priority over host and core writes in the same cycle. It leaves `h_rxf` unchanged.
- R6: A host command write with value 1 sets command-pending. A host write with value 0 clears it, and so does a core acknowledge strobe. A set and an acknowledge in the same cycle leave it set.
- R7: DMA-enabled reads 1 while either mode bit is 1. With both mode bits at 0, it stays 1 while a word is still staged in either direction after DMA was enabled. It drops in the cycle both paths are empty.
- R8: Status bits 3 and 4 show the host flags from the last control write.
- R9: `dma_rx_req` equals receive-full and `dma_tx_req` equals transmit-empty at all times.
- R10: While receive-full is 1, a staged host word stays staged and `c_rx_data` keeps its value. While `h_rxf` is 1, a staged core word stays staged and `h_rx_data` keeps its value.
- R11: If the core reads while a host word is staged, receive-full reads 0 for exactly one cycle. The staged word then arrives at the following edge.
- R12: `c_irq` is 1 exactly when command-pending and `c_irq_en` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_tx_wr | input | 1 | Host write strobe for the transmit pair |
| h_tx_data | input | DATA_W | Host word to send |
| h_txe | output | 1 | Host transmit pair empty (no staged word) |
| h_rx_rd | input | 1 | Host read strobe for the receive pair |
| h_rx_data | output | DATA_W | Word delivered to the host |
| h_rxf | output | 1 | Host receive pair holds an unread word |
| h_ctl_wr | input | 1 | Host control register write strobe |
| h_ctl_flags | input | 2 | General host flags |
| h_ctl_mode | input | 2 | Host DMA mode bits |
| h_init | input | 1 | Initialize strobe |
| h_cmd_wr | input | 1 | Host command register write strobe |
| h_cmd_val | input | 1 | Command bit value written |
| c_rx_rd | input | 1 | Core read strobe for the receive register |
| c_rx_data | output | DATA_W | Word delivered to the core |
| c_tx_wr | input | 1 | Core write strobe for the transmit register |
| c_tx_data | input | DATA_W | Core word to send |
| c_status | output | 16 | Core status word |
| c_irq_en | input | 1 | Command interrupt enable |
| c_cmd_ack | input | 1 | Core command-service acknowledge strobe |
| c_irq | output | 1 | Command interrupt request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The bench targets these corner cases:
- A second host word arriving while receive-full is still set. A design without the hold would overwrite the unread word on `c_rx_data`.
- A core read while a word is staged. A design that moves the word in the same edge would never show receive-full at 0.
- An initialize strobe that coincides with writes, and stale staged words resurfacing after an initialize.
- An acknowledge that coincides with a host set.
- DMA-enabled after the mode bits clear with a word still in flight. A design that decodes only the mode bits would drop the indication too early.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int STAT_W  = 16;
    localparam int ST_RXF  = 0;
    localparam int ST_TXE  = 1;
    localparam int ST_CMD  = 2;
    localparam int ST_FLG0 = 3;
    localparam int ST_FLG1 = 4;
    localparam int ST_DMA  = 5;

    typedef enum logic {H2C_IDLE, H2C_HELD}    h2c_st_t;
    typedef enum logic {C2H_EMPTY, C2H_LOADED} c2h_st_t;
    typedef enum logic {CMD_IDLE, CMD_PEND}    cmd_st_t;
    typedef enum logic {DMA_IDLE, DMA_ARMED}   dma_st_t;
endpackage

// File: rtl/mbox_h2c.sv
module mbox_h2c
    import mbox_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              h_wr,
    input  logic [DATA_W-1:0] h_data,
    input  logic              c_rd,
    output logic [DATA_W-1:0] c_data,
    output logic              rx_full,
    output logic              held
);
    h2c_st_t           st_q, st_d;
    logic [DATA_W-1:0] stage_q;
    logic [DATA_W-1:0] rx_q;
    logic              full_q;
    logic              xfer;

    assign xfer = (st_q == H2C_HELD) && !full_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            H2C_IDLE: if (h_wr) st_d = H2C_HELD;
            H2C_HELD: if (h_wr) st_d = H2C_HELD;
                      else if (xfer) st_d = H2C_IDLE;
        endcase
        if (init) st_d = H2C_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= H2C_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q  <= 1'b0;
            rx_q    <= '0;
            stage_q <= '0;
        end else begin
            if (init) begin
                full_q <= 1'b0;
            end else if (xfer) begin
                full_q <= 1'b1;
                rx_q   <= stage_q;
            end else if (c_rd) begin
                full_q <= 1'b0;
            end
            if (h_wr && !init) stage_q <= h_data;
        end
    end

    assign c_data  = rx_q;
    assign rx_full = full_q;
    assign held    = (st_q == H2C_HELD);

    p_set_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !rx_full && !init) |=> (rx_full && c_data == $past(stage_q)));
    p_rd_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rd && rx_full && !init) |=> !rx_full);
    p_keep_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !c_rd && !init) |=> (rx_full && $stable(c_data)));
    p_late_move_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rd && rx_full && held && !init && !h_wr) |=> (!rx_full && held));
    p_init_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (!rx_full && !held));
endmodule

// File: rtl/mbox_c2h.sv
module mbox_c2h
    import mbox_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              c_wr,
    input  logic [DATA_W-1:0] c_data,
    input  logic              h_rd,
    output logic [DATA_W-1:0] h_data,
    output logic              h_full,
    output logic              tx_empty
);
    c2h_st_t           st_q, st_d;
    logic [DATA_W-1:0] stage_q;
    logic [DATA_W-1:0] hrx_q;
    logic              hfull_q;
    logic              xfer;

    assign xfer = (st_q == C2H_LOADED) && !hfull_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            C2H_EMPTY:  if (c_wr) st_d = C2H_LOADED;
            C2H_LOADED: if (c_wr) st_d = C2H_LOADED;
                        else if (xfer) st_d = C2H_EMPTY;
        endcase
        if (init) st_d = C2H_EMPTY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= C2H_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hfull_q <= 1'b0;
            hrx_q   <= '0;
            stage_q <= '0;
        end else begin
            if (xfer && !init) begin
                hfull_q <= 1'b1;
                hrx_q   <= stage_q;
            end else if (h_rd) begin
                hfull_q <= 1'b0;
            end
            if (c_wr && !init) stage_q <= c_data;
        end
    end

    assign h_data   = hrx_q;
    assign h_full   = hfull_q;
    assign tx_empty = (st_q == C2H_EMPTY);

    p_wr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && !init) |=> !tx_empty);
    p_move_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_empty && !h_full && !c_wr && !init) |=> (tx_empty && h_full));
    p_host_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (h_full && !h_rd) |=> (h_full && $stable(h_data)));
    p_init_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> tx_empty);
endmodule

// File: rtl/mbox_cmd.sv
module mbox_cmd
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic h_wr,
    input  logic h_val,
    input  logic ack,
    input  logic irq_en,
    output logic pend,
    output logic irq
);
    cmd_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CMD_IDLE: if (h_wr && h_val) st_d = CMD_PEND;
            CMD_PEND: if (h_wr && h_val) st_d = CMD_PEND;
                      else if (h_wr || ack) st_d = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CMD_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        pend = (st_q == CMD_PEND);
        irq  = pend && irq_en;
    end

    p_host_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_val) |=> pend);
    p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !(h_wr && h_val)) |=> !pend);
    p_host_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && !h_val) |=> !pend);
endmodule

// File: rtl/mbox_dma.sv
module mbox_dma
    import mbox_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       busy,
    output logic       dma_on
);
    dma_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DMA_IDLE:  if (|mode) st_d = DMA_ARMED;
            DMA_ARMED: if (!(|mode) && !busy) st_d = DMA_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= DMA_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        dma_on = (|mode) || ((st_q == DMA_ARMED) && busy);
    end

    p_mode_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|mode) |-> dma_on);
    p_idle_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|mode) && !busy) |-> !dma_on);
    p_drain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|mode) && busy) |=> (busy -> dma_on));
endmodule

// File: rtl/mbox_top.sv
module mbox_top
    import mbox_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_tx_wr,
    input  logic [DATA_W-1:0] h_tx_data,
    output logic              h_txe,
    input  logic              h_rx_rd,
    output logic [DATA_W-1:0] h_rx_data,
    output logic              h_rxf,
    input  logic              h_ctl_wr,
    input  logic [1:0]        h_ctl_flags,
    input  logic [1:0]        h_ctl_mode,
    input  logic              h_init,
    input  logic              h_cmd_wr,
    input  logic              h_cmd_val,
    input  logic              c_rx_rd,
    output logic [DATA_W-1:0] c_rx_data,
    input  logic              c_tx_wr,
    input  logic [DATA_W-1:0] c_tx_data,
    output logic [STAT_W-1:0] c_status,
    input  logic              c_irq_en,
    input  logic              c_cmd_ack,
    output logic              c_irq,
    output logic              dma_rx_req,
    output logic              dma_tx_req
);
    logic [1:0] flags_q;
    logic [1:0] mode_q;
    logic       rx_full, held, tx_empty, cmd_pend, dma_on;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= 2'b00;
            mode_q  <= 2'b00;
        end else if (h_ctl_wr) begin
            flags_q <= h_ctl_flags;
            mode_q  <= h_ctl_mode;
        end
    end

    mbox_h2c #(.DATA_W(DATA_W)) u_h2c (
        .clk(clk), .rst_n(rst_n), .init(h_init),
        .h_wr(h_tx_wr), .h_data(h_tx_data),
        .c_rd(c_rx_rd), .c_data(c_rx_data),
        .rx_full(rx_full), .held(held)
    );

    mbox_c2h #(.DATA_W(DATA_W)) u_c2h (
        .clk(clk), .rst_n(rst_n), .init(h_init),
        .c_wr(c_tx_wr), .c_data(c_tx_data),
        .h_rd(h_rx_rd), .h_data(h_rx_data),
        .h_full(h_rxf), .tx_empty(tx_empty)
    );

    mbox_cmd u_cmd (
        .clk(clk), .rst_n(rst_n),
        .h_wr(h_cmd_wr), .h_val(h_cmd_val), .ack(c_cmd_ack),
        .irq_en(c_irq_en), .pend(cmd_pend), .irq(c_irq)
    );

    mbox_dma u_dma (
        .clk(clk), .rst_n(rst_n), .mode(mode_q),
        .busy(held || !tx_empty), .dma_on(dma_on)
    );

    always_comb begin
        c_status          = '0;
        c_status[ST_RXF]  = rx_full;
        c_status[ST_TXE]  = tx_empty;
        c_status[ST_CMD]  = cmd_pend;
        c_status[ST_FLG0] = flags_q[0];
        c_status[ST_FLG1] = flags_q[1];
        c_status[ST_DMA]  = dma_on;
        h_txe             = !held;
        dma_rx_req        = rx_full;
        dma_tx_req        = tx_empty;
    end

    p_flag_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        h_ctl_wr |=> (c_status[ST_FLG1:ST_FLG0] == $past(h_ctl_flags)));
    p_irq_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cmd_wr && h_cmd_val && c_irq_en) |=> (c_irq || !c_irq_en));
endmodule

// File: tb/mbox_top_test.sv
`timescale 1ns/1ps
module mbox_top_test;
    localparam int DW = 24;
    logic clk = 1'b0, rst_n = 1'b0;
    logic h_tx_wr = 0, h_rx_rd = 0, h_ctl_wr = 0, h_init = 0, h_cmd_wr = 0, h_cmd_val = 0;
    logic c_rx_rd = 0, c_tx_wr = 0, c_irq_en = 0, c_cmd_ack = 0;
    logic [1:0] h_ctl_flags = 0, h_ctl_mode = 0;
    logic [DW-1:0] h_tx_data = 0, c_tx_data = 0;
    logic h_txe, h_rxf, c_irq, dma_rx_req, dma_tx_req;
    logic [DW-1:0] h_rx_data, c_rx_data;
    logic [15:0] c_status;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mbox_top #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .h_tx_wr(h_tx_wr), .h_tx_data(h_tx_data), .h_txe(h_txe),
        .h_rx_rd(h_rx_rd), .h_rx_data(h_rx_data), .h_rxf(h_rxf), .h_ctl_wr(h_ctl_wr),
        .h_ctl_flags(h_ctl_flags), .h_ctl_mode(h_ctl_mode), .h_init(h_init),
        .h_cmd_wr(h_cmd_wr), .h_cmd_val(h_cmd_val), .c_rx_rd(c_rx_rd), .c_rx_data(c_rx_data),
        .c_tx_wr(c_tx_wr), .c_tx_data(c_tx_data), .c_status(c_status), .c_irq_en(c_irq_en),
        .c_cmd_ack(c_cmd_ack), .c_irq(c_irq), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_wr(input logic [DW-1:0] d);
        h_tx_wr = 1; h_tx_data = d; step(); h_tx_wr = 0;
    endtask
    task automatic host_rd(); h_rx_rd = 1; step(); h_rx_rd = 0; endtask
    task automatic core_rd(); c_rx_rd = 1; step(); c_rx_rd = 0; endtask
    task automatic core_wr(input logic [DW-1:0] d);
        c_tx_wr = 1; c_tx_data = d; step(); c_tx_wr = 0;
    endtask
    task automatic ctl_wr(input logic [1:0] f, input logic [1:0] m);
        h_ctl_wr = 1; h_ctl_flags = f; h_ctl_mode = m; step(); h_ctl_wr = 0;
    endtask
    task automatic cmd_wr(input logic v);
        h_cmd_wr = 1; h_cmd_val = v; step(); h_cmd_wr = 0;
    endtask
    task automatic ack(); c_cmd_ack = 1; step(); c_cmd_ack = 0; endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1;
        // R2 reset state
        chk("R2 status", c_status, 32'h0002);
        chk("R2 h_txe", h_txe, 1);
        chk("R2 h_rxf", h_rxf, 0);
        chk("R2 irq", c_irq, 0);
        chk("R9 reset reqs", {dma_rx_req, dma_tx_req}, 2'b01);

        // R3/R9 host-to-core sweep
        for (int i = 0; i < 6; i++) begin
            logic [DW-1:0] w;
            w = 24'h5A0000 + 24'h010203 * i;
            host_wr(w);
            chk("R3 staged h_txe", h_txe, 0);
            chk("R3 not yet full", c_status[0], 0);
            step();
            chk("R3 full set", c_status[0], 1);
            chk("R3 word", c_rx_data, w);
            chk("R9 rx req", dma_rx_req, 1);
            chk("R3 h_txe back", h_txe, 1);
            core_rd();
            chk("R3 read clears", c_status[0], 0);
            chk("R9 rx req off", dma_rx_req, 0);
        end

        // R10/R11 hold and one-cycle gap
        host_wr(24'hAAAA01); step();
        host_wr(24'hBBBB02); step(2);
        chk("R10 word kept", c_rx_data, 24'hAAAA01);
        chk("R10 still staged", h_txe, 0);
        core_rd();
        chk("R11 gap cycle", c_status[0], 0);
        step();
        chk("R11 late full", c_status[0], 1);
        chk("R11 late word", c_rx_data, 24'hBBBB02);
        core_rd();

        // R4/R9 core-to-host sweep
        for (int i = 0; i < 4; i++) begin
            logic [DW-1:0] w;
            w = 24'h30C000 + 24'h001111 * i;
            core_wr(w);
            chk("R4 txe clears", c_status[1], 0);
            chk("R9 tx req off", dma_tx_req, 0);
            step();
            chk("R4 txe sets", c_status[1], 1);
            chk("R4 h_rxf", h_rxf, 1);
            chk("R4 host word", h_rx_data, w);
            host_rd();
            chk("R4 host read clears", h_rxf, 0);
        end
        core_wr(24'h111111); step();
        core_wr(24'h222222); step(2);
        chk("R10 core word staged", c_status[1], 0);
        chk("R10 host word kept", h_rx_data, 24'h111111);
        host_rd();
        chk("R10 host read", h_rxf, 0);
        step();
        chk("R10 second word", h_rx_data, 24'h222222);
        chk("R10 second full", h_rxf, 1);

        // R5 initialize (h_rxf remains 1 here)
        core_wr(24'h333333);
        host_wr(24'h444444); step();
        host_wr(24'h555555);
        h_init = 1; step(); h_init = 0;
        chk("R5 txe set", c_status[1], 1);
        chk("R5 full clear", c_status[0], 0);
        chk("R5 h_txe", h_txe, 1);
        chk("R5 h_rxf kept", h_rxf, 1);
        step(2);
        chk("R5 no stale host word", c_status[0], 0);
        host_rd(); step(2);
        chk("R5 no stale core word", h_rxf, 0);
        h_init = 1; c_tx_wr = 1; h_tx_wr = 1; c_tx_data = 24'h666666; h_tx_data = 24'h777777;
        step();
        h_init = 0; c_tx_wr = 0; h_tx_wr = 0;
        chk("R5 init beats core wr", c_status[1], 1);
        chk("R5 init beats host wr", h_txe, 1);
        step(2);
        chk("R5 nothing moved", {c_status[0], h_rxf}, 2'b00);

        // R1/R7/R8 control sweep while idle
        for (int f = 0; f < 4; f++) begin
            for (int m = 0; m < 4; m++) begin
                ctl_wr(f[1:0], m[1:0]);
                chk("R8 flags", c_status[4:3], f);
                chk("R7 dma bit", c_status[5], (m != 0));
                chk("R1 upper zero", c_status[15:6], 0);
            end
        end
        ctl_wr(2'b00, 2'b00);
        chk("R7 idle off", c_status[5], 0);

        // R6/R12 command sweep
        for (int e = 0; e < 2; e++) begin
            c_irq_en = e[0];
            cmd_wr(1);
            chk("R6 pend set", c_status[2], 1);
            chk("R12 irq", c_irq, e[0]);
            ack();
            chk("R6 ack clears", c_status[2], 0);
            chk("R12 irq off", c_irq, 0);
            cmd_wr(1);
            cmd_wr(0);
            chk("R6 host clears", c_status[2], 0);
            h_cmd_wr = 1; h_cmd_val = 1; c_cmd_ack = 1; step();
            h_cmd_wr = 0; c_cmd_ack = 0;
            chk("R6 set beats ack", c_status[2], 1);
            chk("R12 irq with set", c_irq, e[0]);
            ack();
        end
        c_irq_en = 0;

        // R7 drain on core-to-host path
        ctl_wr(2'b00, 2'b01);
        core_wr(24'h0D0001); step();
        core_wr(24'h0D0002);
        ctl_wr(2'b00, 2'b00);
        chk("R7 drain core path", c_status[5], 1);
        step(2);
        chk("R7 still draining", c_status[5], 1);
        host_rd();
        chk("R7 before move", c_status[5], 1);
        step();
        chk("R7 drained", c_status[5], 0);
        host_rd();

        // R7 drain on host-to-core path
        ctl_wr(2'b00, 2'b10);
        host_wr(24'h0E0001); step();
        host_wr(24'h0E0002);
        ctl_wr(2'b00, 2'b00);
        chk("R7 drain host path", c_status[5], 1);
        core_rd();
        chk("R7 gap still on", c_status[5], 1);
        step();
        chk("R7 host path drained", c_status[5], 0);
        core_rd();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule